// File: doc/BRIEF.md
# Cascadable Serial Control Word Decoder

This block sits behind a serial port, which hands it parallel 16-bit words with a one-cycle valid strobe. Each word names a device position in a daisy chain, a read or write operation, one of eight 8-bit configuration registers and a data byte. A word whose device field is zero is meant for this device. It either writes its byte into the chosen register or reads that register back. A read returns the register contents in the data byte of a word sent to the serial output. A word aimed further down the chain has its device field reduced by one and is passed on.

A mode input selects how words with the top flag low are treated. In program mode they are invalid control words and are dropped. In mixed program/data mode they are sample data: they touch no register and are passed on unchanged. Serial shifting, framing and the meaning of individual register bits belong to other blocks.

Top module: `cascade_ctl_decoder`

## Requirements
- R1: While rst_ni is low and after it rises, every register reads 0x00 on regs_o and tx_valid_o is low.
- R2: Word layout: bit 15 control flag (1 = control), bit 14 direction (1 = read), bits 13:11 device field, bits 10:8 register select, bits 7:0 data. A control word with device field 0 and direction 0 writes its data byte into the selected register, visible on regs_o[8*k+7:8*k] for register k after the clock edge that samples the word.
- R3: A selected write word produces no output word.
- R4: A control word with a nonzero device field is output with that field decremented by one and all other bits unchanged.
- R5: A control word with device field 0 and direction 1 is output with bits 15:8 unchanged and bits 7:0 replaced by the selected register's contents, including a write made one cycle earlier.
- R6: In program mode (mixed_mode_i = 0) a word with bit 15 low produces no output and changes no register.
- R7: In mixed mode (mixed_mode_i = 1) a word with bit 15 low is output unchanged and changes no register.
- R8: tx_valid_o is high for exactly the cycle after each rx_valid_i cycle whose word is forwarded, read back or passed, and low at all other times.
- R9: A forwarded control word does not modify any register of this device, whatever its direction bit.
- R10: Words on consecutive cycles are each decoded, and outputs appear back to back in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mixed_mode_i | input | 1 | 1 = mixed program/data mode, 0 = program mode |
| rx_word_i | input | 16 | Received word |
| rx_valid_i | input | 1 | rx_word_i is valid this cycle |
| tx_word_o | output | 16 | Word for the serial output |
| tx_valid_o | output | 1 | tx_word_o is valid this cycle |
| regs_o | output | 64 | Register contents, register k at bits 8k+7:8k |

## Verification
The bench targets device fields of one and of seven. A design that compared against the wrong value or failed to decrement would either consume a word meant for a later device or send out a wrong address. It reads a register in the cycle right after writing it, which exposes a read path that returns the old value. It sends invalid words in program mode and data words in mixed mode: a design that ignored the mode would drop sample data or pass invalid control words along. Forwarded words with the write direction check that a register changes only when the device field is zero.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_WRITE = 3'd1,
    ACT_READ  = 3'd2,
    ACT_FWD   = 3'd3,
    ACT_PASS  = 3'd4
  } act_e;
endpackage

// File: rtl/cwd_field_decode.sv
module cwd_field_decode #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int DEV_W  = 3,
  localparam int WORD_W = 2 + DEV_W + SEL_W + DATA_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              mixed_i,
  output cwd_pkg::act_e     act_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DATA_W-1:0] data_o,
  output logic [WORD_W-1:0] fwd_word_o
);
  localparam int SEL_LSB = DATA_W;
  localparam int DEV_LSB = DATA_W + SEL_W;
  localparam int RD_BIT  = WORD_W - 2;
  localparam int CTL_BIT = WORD_W - 1;

  logic [DEV_W-1:0] dev;
  logic             is_ctl;
  logic             is_rd;

  assign dev    = word_i[DEV_LSB +: DEV_W];
  assign is_ctl = word_i[CTL_BIT];
  assign is_rd  = word_i[RD_BIT];
  assign sel_o  = word_i[SEL_LSB +: SEL_W];
  assign data_o = word_i[DATA_W-1:0];

  always_comb begin
    fwd_word_o = word_i;
    fwd_word_o[DEV_LSB +: DEV_W] = dev - DEV_W'(1);
  end

  always_comb begin
    act_o = cwd_pkg::ACT_NONE;
    if (valid_i) begin
      if (!is_ctl) begin
        // low flag: sample data in mixed mode, invalid otherwise
        if (mixed_i) act_o = cwd_pkg::ACT_PASS;
      end else if (dev != '0) begin
        act_o = cwd_pkg::ACT_FWD;
      end else if (is_rd) begin
        act_o = cwd_pkg::ACT_READ;
      end else begin
        act_o = cwd_pkg::ACT_WRITE;
      end
    end
  end
endmodule

// File: rtl/cwd_reg_bank.sv
module cwd_reg_bank #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int NUM_REGS = 1 << SEL_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[g] <= '0;
      end else if (we_i && (sel_i == SEL_W'(g))) begin
        q[g] <= wdata_i;
      end
    end
    assign regs_o[g*DATA_W +: DATA_W] = q[g];
  end

  assign rdata_o = q[sel_i];
endmodule

// File: rtl/cwd_tx_stage.sv
module cwd_tx_stage #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int DEV_W  = 3,
  localparam int WORD_W = 2 + DEV_W + SEL_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cwd_pkg::act_e     act_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] fwd_word_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              tx_valid_o
);
  logic [WORD_W-1:0] nxt_word;
  logic              nxt_valid;

  always_comb begin
    nxt_word  = word_i;
    nxt_valid = 1'b1;
    unique case (act_i)
      cwd_pkg::ACT_FWD:  nxt_word = fwd_word_i;
      cwd_pkg::ACT_READ: nxt_word = {word_i[WORD_W-1:DATA_W], rdata_i};
      cwd_pkg::ACT_PASS: nxt_word = word_i;
      default:           nxt_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_word_o  <= '0;
      tx_valid_o <= 1'b0;
    end else begin
      tx_valid_o <= nxt_valid;
      if (nxt_valid) tx_word_o <= nxt_word;
    end
  end
endmodule

// File: rtl/cascade_ctl_decoder.sv
module cascade_ctl_decoder #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int DEV_W  = 3,
  localparam int WORD_W   = 2 + DEV_W + SEL_W + DATA_W,
  localparam int NUM_REGS = 1 << SEL_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       mixed_mode_i,
  input  logic [WORD_W-1:0]          rx_word_i,
  input  logic                       rx_valid_i,
  output logic [WORD_W-1:0]          tx_word_o,
  output logic                       tx_valid_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  cwd_pkg::act_e     act;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic [WORD_W-1:0] fwd_word;

  cwd_field_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W), .DEV_W(DEV_W)) u_dec (
    .word_i     (rx_word_i),
    .valid_i    (rx_valid_i),
    .mixed_i    (mixed_mode_i),
    .act_o      (act),
    .sel_o      (sel),
    .data_o     (wdata),
    .fwd_word_o (fwd_word)
  );

  cwd_reg_bank #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (act == cwd_pkg::ACT_WRITE),
    .sel_i   (sel),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .regs_o  (regs_o)
  );

  cwd_tx_stage #(.DATA_W(DATA_W), .SEL_W(SEL_W), .DEV_W(DEV_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .word_i     (rx_word_i),
    .fwd_word_i (fwd_word),
    .rdata_i    (rdata),
    .tx_word_o  (tx_word_o),
    .tx_valid_o (tx_valid_o)
  );
endmodule

// File: rtl/cascade_ctl_decoder_chk.sv
module cascade_ctl_decoder_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int DEV_W  = 3,
  localparam int WORD_W   = 2 + DEV_W + SEL_W + DATA_W,
  localparam int NUM_REGS = 1 << SEL_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       mixed_mode_i,
  input logic [WORD_W-1:0]          rx_word_i,
  input logic                       rx_valid_i,
  input logic [WORD_W-1:0]          tx_word_o,
  input logic                       tx_valid_o,
  input logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int DEV_LSB = DATA_W + SEL_W;

  logic             ctl;
  logic             rd;
  logic [DEV_W-1:0] dev;
  logic             sel_wr;

  assign ctl    = rx_word_i[WORD_W-1];
  assign rd     = rx_word_i[WORD_W-2];
  assign dev    = rx_word_i[DEV_LSB +: DEV_W];
  assign sel_wr = rx_valid_i && ctl && (dev == '0) && !rd;

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !tx_valid_o && (regs_o == '0)); // R1

  AST_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> !tx_valid_o); // R3

  AST_FWD_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && ctl && (dev != '0) |=> tx_valid_o &&
      (tx_word_o[DEV_LSB +: DEV_W] == $past(dev) - DEV_W'(1))); // R4

  AST_READ_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && ctl && (dev == '0) && rd |=> tx_valid_o &&
      (tx_word_o[WORD_W-1:DATA_W] == $past(rx_word_i[WORD_W-1:DATA_W]))); // R5

  AST_PROG_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !ctl && !mixed_mode_i |=> !tx_valid_o); // R6

  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !ctl && mixed_mode_i |=> tx_valid_o &&
      (tx_word_o == $past(rx_word_i))); // R7

  AST_TX_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(rx_valid_i)); // R8

  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> $stable(regs_o)); // R9
endmodule

bind cascade_ctl_decoder cascade_ctl_decoder_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .DEV_W(DEV_W)
) chk_i (.*);

// File: tb/cascade_ctl_decoder_tb_top.sv
module cascade_ctl_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mixed = 1'b0;
  logic [15:0] rx_word = '0;
  logic        rx_valid = 1'b0;
  logic [15:0] tx_word;
  logic        tx_valid;
  logic [63:0] regs;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  model [8];
  logic [15:0] exp_q [$];
  string       req_q [$];

  always #4ns clk = ~clk;

  cascade_ctl_decoder dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mixed_mode_i (mixed),
    .rx_word_i    (rx_word),
    .rx_valid_i   (rx_valid),
    .tx_word_o    (tx_word),
    .tx_valid_o   (tx_valid),
    .regs_o       (regs)
  );

  function automatic logic [15:0] mk(bit c, bit r, int dv, int sl, int dt);
    return {c, r, 3'(dv), 3'(sl), 8'(dt)};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one word per call, expectation pushed for every output word
  task automatic send(logic [15:0] w, bit md, string req);
    @(negedge clk);
    mixed    = md;
    rx_word  = w;
    rx_valid = 1'b1;
    if (w[15]) begin
      if (w[13:11] != 3'd0) begin
        exp_q.push_back({w[15:14], w[13:11] - 3'd1, w[10:0]});
        req_q.push_back(req);
      end else if (w[14]) begin
        exp_q.push_back({w[15:8], model[w[10:8]]});
        req_q.push_back(req);
      end else begin
        model[w[10:8]] = w[7:0];
      end
    end else if (md) begin
      exp_q.push_back(w);
      req_q.push_back(req);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b0;
    end
  endtask

  task automatic check_regs(string req);
    logic [63:0] e;
    for (int k = 0; k < 8; k++) e[k*8 +: 8] = model[k];
    check(regs == e, req, regs, e);
  endtask

  // monitor: R8, outputs appear only when expected
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected output", 64'(tx_word), 64'h0);
      end else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(tx_word == e, r, 64'(tx_word), 64'(e));
      end
    end else if (rst_n && !tx_valid && exp_q.size() != 0 && !rx_valid) begin
      check(1'b0, "R8 missing output", 64'(exp_q.size()), 64'h0);
      void'(exp_q.pop_front());
      void'(req_q.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    check(regs == 64'h0 && !tx_valid, "R1 in reset", {regs[62:0], tx_valid}, 64'h0);
    rst_n = 1'b1;
    idle(2);
    check(regs == 64'h0 && !tx_valid, "R1 after reset", {regs[62:0], tx_valid}, 64'h0);

    // R2, R3: selected writes to every register, nothing forwarded
    for (int k = 0; k < 8; k++) send(mk(1, 0, 0, k, 8'h11 * (k + 1) + 3), 1'b0, "R3");
    idle(2);
    check_regs("R2 writes");

    // R5: reads of each register, including the top one
    for (int k = 0; k < 8; k++) send(mk(1, 1, 0, k, 8'h5A), 1'b0, "R5 read");
    idle(2);

    // R5: read right after write
    send(mk(1, 0, 0, 4, 8'hC3), 1'b1, "R2");
    send(mk(1, 1, 0, 4, 8'h00), 1'b1, "R5 read-after-write");
    idle(2);
    check_regs("R2 write before read");

    // R4, R9: forwarded words, both directions, device fields 1 and 7
    send(mk(1, 0, 1, 2, 8'hEE), 1'b0, "R4 dev1 write fwd");
    send(mk(1, 1, 7, 6, 8'h77), 1'b0, "R4 dev7 read fwd");
    send(mk(1, 0, 7, 0, 8'hFF), 1'b1, "R4 dev7 write fwd");
    idle(2);
    check_regs("R9 forwarded writes");

    // R6: program mode drops low-flag words
    send(mk(0, 0, 0, 1, 8'h99), 1'b0, "R6");
    send(mk(0, 1, 3, 5, 8'h42), 1'b0, "R6");
    idle(3);
    check_regs("R6 no reg change");

    // R7: mixed mode passes data words unchanged
    send(mk(0, 0, 0, 1, 8'h99), 1'b1, "R7 pass");
    send(16'h3FFF, 1'b1, "R7 pass all ones");
    idle(2);
    check_regs("R7 no reg change");

    // R10: mixed back-to-back stream
    send(mk(1, 1, 2, 3, 8'h01), 1'b1, "R10 fwd");
    send(mk(1, 0, 0, 3, 8'hA5), 1'b1, "R10 write");
    send(mk(0, 1, 1, 1, 8'h10), 1'b1, "R10 data");
    send(mk(1, 1, 0, 3, 8'h00), 1'b1, "R10 read");
    send(mk(0, 0, 0, 0, 8'h20), 1'b0, "R10 dropped");
    send(mk(1, 1, 0, 0, 8'h00), 1'b0, "R10 read");
    idle(3);
    check_regs("R10 final regs");
    check(exp_q.size() == 0, "R8 drained", 64'(exp_q.size()), 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule